// File: doc/BRIEF.md
# Buffered-Divider Up-Counting Timebase

This block is the counting core of a timer. A programmable divider turns the system clock into count ticks. A 16-bit counter steps up once per tick and returns to zero after it reaches a programmable top value. Software reaches the block through a small single-cycle register bus. Writes to the divider and top registers land in staging copies and read back at once. The counting logic uses separate working copies. These are refreshed only by an update event.

An update event comes from one of two sources. The first is the counter wrapping from the top value to zero. The second is a software strobe. An update block bit suppresses both sources. On an update event the block copies the staged values into the working copies and restarts the divider. It also raises a one-cycle pulse output and sets a sticky flag. An interrupt line is the flag gated by an enable bit. A run bit pauses and resumes counting and leaves every other setting as it is. Software can overwrite the count at any time.

Register map, by bus address. Address 0 is control: bit 0 is run, bit 1 is update block, bit 2 is interrupt enable. Address 1 is status: bit 0 is the update flag. Address 2 is the strobe register, which is write-only and reads as 0. Address 3 is the count. Address 4 is the staged divider value. Address 5 is the staged top value.

Top module: `preload_timebase`

## Requirements
- R1: After reset, control reads 0, the staged divider reads 0x0000, the staged top reads 0xFFFF, the count reads 0, status reads 0, and irq and upd_pulse are low.
- R2: While control bit 0 (run) is 1 and the working divider value is P, the count rises by one every P+1 clocks. From the working top value it goes back to 0.
- R3: While run is 0, the count holds. The divider, top and control settings read back unchanged.
- R4: A write to address 4 reads back on the next read. The count rate changes only after the next update event.
- R5: A write to address 5 reads back on the next read. The wrap point changes only after the next update event.
- R6: Writing 1 to bit 0 of address 2 while update block is 0 does four things. It copies both staged values into the working copies, clears the count and the divider, sets the status flag, and pulses upd_pulse on the next cycle.
- R7: While control bit 1 (update block) is 1, the strobe does nothing and leaves the count untouched. A wrap still returns the count to 0, but it loads no working copy, sets no flag and gives no pulse.
- R8: A write to address 3 replaces the count. It takes priority over a tick in the same cycle.
- R9: Each wrap with update block at 0 is an update event. The event loads the working copies, sets the flag and drives upd_pulse high for one cycle.
- R10: The status flag stays set until status is written with bit 0 at 0. Writing 1 leaves it unchanged. irq is high exactly when the flag is set and control bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write enable for this cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr, combinational |
| upd_pulse | output | 1 | One-cycle pulse after each update event |
| irq | output | 1 | Update flag gated by the interrupt enable |

## Verification
The counter is run with a divide of one and with a divide of three. It is also run against the reset top of 0xFFFF and against staged tops of 5 and 3, so that each count read shows which working values are in use.

Each staged write is followed by reads taken both before and after an update event. These reads separate "read back at once" from "acted upon". A strobe taken while updates are blocked, and a wrap taken while updates are blocked, show whether the working copies, the flag or the pulse were touched. Pulse counts over a fixed window check the wrap period. A count write timed on a tick checks write priority.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned SEL_DIV = 0;
    localparam int unsigned SEL_TOP = 1;
    localparam int unsigned NUM_SEL = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_STAT  = 3'd1,
        RA_EVT   = 3'd2,
        RA_COUNT = 3'd3,
        RA_DIV   = 3'd4,
        RA_TOP   = 3'd5
    } reg_addr_e;

    // control word, bit 0 = run, bit 1 = update block, bit 2 = irq enable
    typedef struct packed {
        logic irq_en;
        logic block;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W     = $bits(ctrl_t);
    localparam ctrl_t       CTRL_RESET = '{irq_en: 1'b0, block: 1'b0, run: 1'b0};

    function automatic logic wr_hit(input logic we,
                                    input logic [ADDR_W-1:0] a,
                                    input reg_addr_e r);
        return we && (a == r);
    endfunction

endpackage

// File: rtl/tmb_shadow.sv
module tmb_shadow #(
    parameter int unsigned W   = 16,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/tmb_presc.sv
module tmb_presc #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] div_act,
    output logic         tick
);

    logic [W-1:0] pcnt_q;
    logic         at_end;

    assign at_end = (pcnt_q == div_act);
    assign tick   = run & at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
        end else if (restart) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= at_end ? '0 : pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmb_count.sv
module tmb_count #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] top_act,
    output logic [W-1:0] count,
    output logic         wrap
);

    logic at_top;

    assign at_top = (count == top_act);
    // a software count write in the same cycle cancels the wrap event
    assign wrap   = tick & at_top & ~wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr) begin
            count <= wdata;
        end else if (clear) begin
            count <= '0;
        end else if (tick) begin
            count <= at_top ? '0 : count + 1'b1;
        end
    end

endmodule

// File: rtl/tmb_regs.sv
module tmb_regs
    import tmb_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [CTRL_W-1:0]          wdata_lo,
    input  logic [W-1:0]               count,
    input  logic [NUM_SEL-1:0][W-1:0]  pre_q,
    input  logic                       upd_evt,
    output logic [W-1:0]               bus_rdata,
    output ctrl_t                      ctrl_q,
    output logic                       flag_q,
    output logic [NUM_SEL-1:0]         pre_wr,
    output logic                       cnt_wr,
    output logic                       sw_strobe
);

    logic ctrl_wr;
    logic stat_wr;

    assign ctrl_wr          = wr_hit(bus_we, bus_addr, RA_CTRL);
    assign stat_wr          = wr_hit(bus_we, bus_addr, RA_STAT);
    assign cnt_wr           = wr_hit(bus_we, bus_addr, RA_COUNT);
    assign sw_strobe        = wr_hit(bus_we, bus_addr, RA_EVT) & wdata_lo[0];
    assign pre_wr[SEL_DIV]  = wr_hit(bus_we, bus_addr, RA_DIV);
    assign pre_wr[SEL_TOP]  = wr_hit(bus_we, bus_addr, RA_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(wdata_lo);
        end
    end

    // set by an update event wins over a clearing write in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (upd_evt) begin
            flag_q <= 1'b1;
        end else if (stat_wr && !wdata_lo[0]) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CTRL:  bus_rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
            RA_STAT:  bus_rdata = {{(W-1){1'b0}}, flag_q};
            RA_COUNT: bus_rdata = count;
            RA_DIV:   bus_rdata = pre_q[SEL_DIV];
            RA_TOP:   bus_rdata = pre_q[SEL_TOP];
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/preload_timebase.sv
module preload_timebase
    import tmb_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              upd_pulse,
    output logic              irq
);

    ctrl_t                      ctrl_q;
    logic                       flag_q;
    logic                       cnt_wr;
    logic                       sw_strobe;
    logic                       strobe_ok;
    logic                       tick;
    logic                       wrap;
    logic                       upd_evt;
    logic [W-1:0]               count_q;
    logic [W-1:0]               psc_act;
    logic [W-1:0]               arr_act;
    logic [NUM_SEL-1:0]         pre_wr;
    logic [NUM_SEL-1:0][W-1:0]  pre_q;
    logic [NUM_SEL-1:0][W-1:0]  act_q;

    assign strobe_ok = sw_strobe & ~ctrl_q.block;
    assign upd_evt   = (wrap & ~ctrl_q.block) | strobe_ok;
    assign psc_act   = act_q[SEL_DIV];
    assign arr_act   = act_q[SEL_TOP];
    assign irq       = flag_q & ctrl_q.irq_en;

    tmb_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .wdata_lo  (bus_wdata[CTRL_W-1:0]),
        .count     (count_q),
        .pre_q     (pre_q),
        .upd_evt   (upd_evt),
        .bus_rdata (bus_rdata),
        .ctrl_q    (ctrl_q),
        .flag_q    (flag_q),
        .pre_wr    (pre_wr),
        .cnt_wr    (cnt_wr),
        .sw_strobe (sw_strobe)
    );

    // staged and working copy for each buffered setting
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_buf
        localparam logic [W-1:0] RSTV = (g == SEL_TOP) ? {W{1'b1}} : {W{1'b0}};

        tmb_shadow #(.W(W), .RST(RSTV)) u_stage (
            .clk  (clk),
            .rst  (rst),
            .load (pre_wr[g]),
            .d    (bus_wdata),
            .q    (pre_q[g])
        );

        tmb_shadow #(.W(W), .RST(RSTV)) u_work (
            .clk  (clk),
            .rst  (rst),
            .load (upd_evt),
            .d    (pre_q[g]),
            .q    (act_q[g])
        );
    end

    tmb_presc #(.W(W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .restart (upd_evt),
        .div_act (psc_act),
        .tick    (tick)
    );

    tmb_count #(.W(W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .clear   (strobe_ok),
        .wr      (cnt_wr),
        .wdata   (bus_wdata),
        .top_act (arr_act),
        .count   (count_q),
        .wrap    (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_pulse <= 1'b0;
        end else begin
            upd_pulse <= upd_evt;
        end
    end

endmodule

// File: rtl/tmb_checker.sv
module tmb_checker #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_we,
    input logic [2:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic         run,
    input logic         block,
    input logic         cnt_wr,
    input logic         strobe_ok,
    input logic         tick,
    input logic [W-1:0] count,
    input logic [W-1:0] arr_act,
    input logic [W-1:0] psc_act,
    input logic         upd_evt,
    input logic         flag,
    input logic         upd_pulse
);

    logic stat_clear;
    logic sw_go;
    logic cnt_write;

    assign stat_clear = bus_we && (bus_addr == 3'd1) && !bus_wdata[0];
    assign sw_go      = bus_we && (bus_addr == 3'd2) && bus_wdata[0] && !block;
    assign cnt_write  = bus_we && (bus_addr == 3'd3);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0) && !flag && !upd_pulse); // R1

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && (count != arr_act) && !cnt_wr && !strobe_ok)
        |=> count == W'($past(count) + 1'b1)); // R2

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && (count == arr_act) && !cnt_wr) |=> (count == '0)); // R2

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr && !strobe_ok) |=> $stable(count)); // R3

    AST_SHADOW_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !upd_evt |=> $stable(arr_act) && $stable(psc_act)); // R5

    AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sw_go |=> (count == '0) && upd_pulse && flag); // R6

    AST_BLOCKED_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        block |=> $stable(arr_act) && $stable(psc_act) && !upd_pulse); // R7

    AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (rst)
        cnt_write |=> (count == $past(bus_wdata))); // R8

    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> flag); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !stat_clear) |=> flag); // R10

endmodule

bind preload_timebase tmb_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (ctrl_q.run),
    .block     (ctrl_q.block),
    .cnt_wr    (cnt_wr),
    .strobe_ok (strobe_ok),
    .tick      (tick),
    .count     (count_q),
    .arr_act   (arr_act),
    .psc_act   (psc_act),
    .upd_evt   (upd_evt),
    .flag      (flag_q),
    .upd_pulse (upd_pulse)
);

// File: tb/preload_timebase_test.sv
`timescale 1ns/1ps
module preload_timebase_test;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_WT = 2'd2;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_EVT  = 3'd2;
    localparam logic [2:0] A_CNT  = 3'd3;
    localparam logic [2:0] A_DIV  = 3'd4;
    localparam logic [2:0] A_TOP  = 3'd5;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 60;
    localparam vec_t VECS [NV] = '{
        '{OP_RD, A_CTRL, 16'd0, 16'h0000, 4'd1},   // R1
        '{OP_RD, A_DIV,  16'd0, 16'h0000, 4'd1},   // R1
        '{OP_RD, A_TOP,  16'd0, 16'hFFFF, 4'd1},   // R1
        '{OP_RD, A_CNT,  16'd0, 16'h0000, 4'd1},   // R1
        '{OP_RD, A_STAT, 16'd0, 16'h0000, 4'd1},   // R1
        '{OP_WR, A_TOP,  16'd5, 16'h0000, 4'd0},
        '{OP_RD, A_TOP,  16'd0, 16'd5,    4'd5},   // R5 staged readback
        '{OP_WR, A_CTRL, 16'd1, 16'h0000, 4'd0},
        '{OP_WT, A_CTRL, 16'd10, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd10,   4'd5},   // R5 top of 5 not yet used
        '{OP_WR, A_EVT,  16'd1, 16'h0000, 4'd0},
        '{OP_RD, A_STAT, 16'd0, 16'd1,    4'd6},   // R6
        '{OP_RD, A_CNT,  16'd0, 16'd0,    4'd6},   // R6
        '{OP_WT, A_CTRL, 16'd3, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd3,    4'd2},   // R2
        '{OP_WT, A_CTRL, 16'd3, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd0,    4'd2},   // R2 wrap at 5
        '{OP_WR, A_STAT, 16'd0, 16'h0000, 4'd0},
        '{OP_RD, A_STAT, 16'd0, 16'd0,    4'd10},  // R10 clear
        '{OP_WR, A_DIV,  16'd2, 16'h0000, 4'd0},
        '{OP_RD, A_DIV,  16'd0, 16'd2,    4'd4},   // R4 staged readback
        '{OP_WT, A_CTRL, 16'd2, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd4,    4'd4},   // R4 rate unchanged
        '{OP_WT, A_CTRL, 16'd2, 16'h0000, 4'd0},
        '{OP_RD, A_STAT, 16'd0, 16'd1,    4'd9},   // R9 wrap sets flag
        '{OP_RD, A_CNT,  16'd0, 16'd0,    4'd9},   // R9
        '{OP_WT, A_CTRL, 16'd3, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd1,    4'd4},   // R4 divide by 3
        '{OP_WT, A_CTRL, 16'd2, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd1,    4'd4},   // R4
        '{OP_WT, A_CTRL, 16'd1, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd2,    4'd4},   // R4
        '{OP_WR, A_CTRL, 16'd0, 16'h0000, 4'd0},
        '{OP_WT, A_CTRL, 16'd10, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd2,    4'd3},   // R3 paused
        '{OP_RD, A_DIV,  16'd0, 16'd2,    4'd3},   // R3
        '{OP_RD, A_TOP,  16'd0, 16'd5,    4'd3},   // R3
        '{OP_WR, A_CNT,  16'd4, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd4,    4'd8},   // R8
        '{OP_WR, A_STAT, 16'd0, 16'h0000, 4'd0},
        '{OP_WR, A_CTRL, 16'd2, 16'h0000, 4'd0},
        '{OP_WR, A_TOP,  16'd3, 16'h0000, 4'd0},
        '{OP_WR, A_EVT,  16'd1, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd4,    4'd7},   // R7 strobe ignored
        '{OP_RD, A_STAT, 16'd0, 16'd0,    4'd7},   // R7
        '{OP_RD, A_CTRL, 16'd0, 16'd2,    4'd7},   // R7
        '{OP_WR, A_CTRL, 16'd3, 16'h0000, 4'd0},
        '{OP_WT, A_CTRL, 16'd5, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd0,    4'd7},   // R7 wrap still happens
        '{OP_RD, A_STAT, 16'd0, 16'd0,    4'd7},   // R7 but no flag
        '{OP_WT, A_CTRL, 16'd12, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd4,    4'd7},   // R7 top still 5
        '{OP_WR, A_CTRL, 16'd1, 16'h0000, 4'd0},
        '{OP_WR, A_EVT,  16'd1, 16'h0000, 4'd0},
        '{OP_RD, A_STAT, 16'd0, 16'd1,    4'd6},   // R6
        '{OP_RD, A_CNT,  16'd0, 16'd0,    4'd6},   // R6
        '{OP_WT, A_CTRL, 16'd12, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd0,    4'd5},   // R5 top of 3 now used
        '{OP_WT, A_CTRL, 16'd3, 16'h0000, 4'd0},
        '{OP_RD, A_CNT,  16'd0, 16'd1,    4'd5}    // R5
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        upd_pulse;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    preload_timebase uut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .upd_pulse (upd_pulse),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic count_pulses(input int n, output int p);
        p = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (upd_pulse) p++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R2 actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int          p;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", {15'd0, irq}, 16'd0);
        check("R1 pulse after reset", {15'd0, upd_pulse}, 16'd0);

        for (int k = 0; k < NV; k++) begin
            case (VECS[k].op)
                OP_WR: wr(VECS[k].addr, VECS[k].data);
                OP_WT: step(int'(VECS[k].data));
                default: begin
                    rd(VECS[k].addr, v);
                    check($sformatf("R%0d vector %0d", VECS[k].req, k), v, VECS[k].exp);
                end
            endcase
        end

        // R10: flag is set here, interrupt masked until enabled
        check("R10 irq masked", {15'd0, irq}, 16'd0);
        wr(A_CTRL, 16'd4);
        check("R10 irq enabled", {15'd0, irq}, 16'd1);
        wr(A_STAT, 16'd1);
        check("R10 write 1 keeps flag", {15'd0, irq}, 16'd1);
        wr(A_STAT, 16'd0);
        check("R10 write 0 clears flag", {15'd0, irq}, 16'd0);

        // R6 strobe pulse, then R9 wrap period with divide 1 and top 3
        wr(A_DIV, 16'd0);
        wr(A_TOP, 16'd3);
        wr(A_EVT, 16'd1);
        check("R6 strobe pulse", {15'd0, upd_pulse}, 16'd1);
        rd(A_CNT, v);
        check("R6 strobe clears count", v, 16'd0);
        step(1);
        check("R9 pulse lasts one cycle", {15'd0, upd_pulse}, 16'd0);
        wr(A_CTRL, 16'd1);
        count_pulses(40, p);
        check("R9 pulses per 40 clocks", 16'(p), 16'd10);

        // R7 blocked wraps give no pulses and no flag
        wr(A_CTRL, 16'd3);
        wr(A_STAT, 16'd0);
        count_pulses(40, p);
        check("R7 no pulses while blocked", 16'(p), 16'd0);
        rd(A_STAT, v);
        check("R7 no flag while blocked", v, 16'd0);

        // R8 count write on a tick, then run on to the wrap
        wr(A_CTRL, 16'd1);
        wr(A_CNT, 16'd2);
        rd(A_CNT, v);
        check("R8 write wins over tick", v, 16'd2);
        step(1);
        rd(A_CNT, v);
        check("R8 counts on from written value", v, 16'd3);
        step(1);
        rd(A_CNT, v);
        check("R9 wrap after written value", v, 16'd0);
        check("R9 wrap pulse", {15'd0, upd_pulse}, 16'd1);

        // R1 reset in the middle of a run
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        rd(A_CTRL, v); check("R1 ctrl", v, 16'h0000);
        rd(A_DIV, v);  check("R1 div", v, 16'h0000);
        rd(A_TOP, v);  check("R1 top", v, 16'hFFFF);
        rd(A_CNT, v);  check("R1 count", v, 16'h0000);
        rd(A_STAT, v); check("R1 stat", v, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 pulse", {15'd0, upd_pulse}, 16'd0);
        wr(A_CTRL, 16'd1);
        step(5);
        rd(A_CNT, v);
        check("R2 counting after reset", v, 16'd5);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule